// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block holds the digital side of a 12-bit successive-approximation analog-to-digital converter. A host reaches it through a small register window with one write strobe and a combinational read path. Setting the start bit while the block is switched on and idle begins a conversion. The controller first holds the sample-and-hold stage in its tracking phase for a programmable number of cycles. It then tests one code bit per cycle, from the most significant bit down to the least. For each test it drives a trial code to an external DAC and comparator and reads back a single decision bit.

When the last bit is decided, the 12-bit code is written into a high/low result pair in one clock edge. In that same edge the start bit, which also serves as the busy indicator, drops and a sticky completion flag rises. The flag drives the interrupt output until software clears it. Reset returns every control field to its default and kills any conversion in progress. Reset leaves the result pair alone, so that pair holds no defined value after power-up.

Channel number and reference choice are plain register fields passed to the analog side. A per-pin analog-select mask, all ones after reset, forces the digital copy of each analog pin to read 0.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset: control word (address 0) reads 0x00; timing/reference word (address 1) reads 0x00; flag word (address 4) reads 0x00; analog-select mask (address 5) reads 0xFF; `irq` and `adc_on` are 0.
- R2: A write to address 0 with bit 0 (on) and bit 1 (start) both set, made while the block is already on and idle, starts a conversion. Bit 1 of address 0 then reads 1 for exactly (S+1)+12 cycles, where S is bits 7:4 of address 1. `sh_sample` is high during the first S+1 of those cycles.
- R3: In the k-th decision cycle (bit index i = 11-k), `dac_code` equals the already-decided upper bits with bit i set and all lower bits clear. The bit is kept when `cmp_hi` is 1 and dropped when it is 0. The final code is therefore the largest code not above the input.
- R4: At completion the address 2 register gets result bits 11:8 in its bits 3:0, and the address 3 register gets bits 7:0. Both change on the same edge.
- R5: Completion clears bit 1 of address 0 and sets bit 0 of address 4, which drives `irq`. The flag stays set until a write of 0 to bit 0 of address 4. A write of 1 there has no effect.
- R6: A start request is ignored while the block is off (bit 0 of address 0 was 0 before the write) or while a conversion is running. A running conversion keeps its length and its result.
- R7: A write to address 0 during a conversion that clears bit 1 or bit 0 stops the conversion on that edge. The result pair and the flag keep their values.
- R8: Reset during a conversion stops it, returns every control field to its R1 value and leaves the result pair unchanged.
- R9: `chan_sel` follows bits 4:2 of address 0, `vref_sel` follows bits 1:0 of address 1, and `adc_on` follows bit 0 of address 0.
- R10: `dig_in[n]` equals `pin_in[n]` when bit n of address 5 is 0 and reads 0 when that bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Sticky completion flag |
| adc_on | output | 1 | Converter powered on |
| chan_sel | output | 3 | Input channel to the analog multiplexer |
| vref_sel | output | 2 | Reference source selection |
| sh_sample | output | 1 | Sample-and-hold tracking phase |
| dac_code | output | 12 | Trial code to the DAC during decisions, else 0 |
| cmp_hi | input | 1 | Comparator: held input at or above trial level |
| pin_in | input | 8 | Digital input of each shared pin |
| dig_in | output | 8 | Digital input after analog masking |

## Verification
The hardest situations to reach are the ones where a host access lands inside a running conversion. These are a repeated start request, an abort write, and a reset pulse that arrives a few cycles into the decision phase. Each case must then be judged only from the ports. The stimulus uses one conversion routine with a cycle-indexed injection point, so a write or a reset pulse is placed at an exact cycle after the start. A comparator model built on a fixed input value makes every trial code predictable, so the routine checks the DAC sequence, the busy length and the untouched result pair or flag against values worked out from the input.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_CONV   = 2'd2
  } sar_state_e;

  // Code presented to the DAC while bit 'idx' is under test (up to 16-bit codes).
  function automatic logic [15:0] sar_trial(input logic [15:0] acc, input logic [3:0] idx);
    return acc | (16'd1 << idx);
  endfunction

  // Decided code after the comparator answer for bit 'idx'.
  function automatic logic [15:0] sar_decide(input logic [15:0] acc, input logic [3:0] idx,
                                             input logic keep);
    logic [15:0] bitm;
    bitm = 16'd1 << idx;
    return keep ? (acc | bitm) : (acc & ~bitm);
  endfunction

endpackage

// File: rtl/sar_pinmux.sv
module sar_pinmux #(
  parameter int NUM_CH = 8
) (
  input  logic [NUM_CH-1:0] ansel,
  input  logic [NUM_CH-1:0] pin_in,
  output logic [NUM_CH-1:0] dig_in
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_pin
    assign dig_in[g] = ansel[g] ? 1'b0 : pin_in[g];
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int RES_BITS = 12,
  parameter int SMP_W    = 4,
  localparam int IDX_W   = $clog2(RES_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                abort,
  input  logic [SMP_W-1:0]    smp_len,
  input  logic                cmp_hi,
  output logic                busy,
  output logic                sh_sample,
  output logic                converting,
  output logic                done,
  output logic [RES_BITS-1:0] result,
  output logic [RES_BITS-1:0] dac_code,
  output logic [RES_BITS-1:0] trial_mask
);
  sar_state_e          state;
  logic [SMP_W-1:0]    cnt;
  logic [IDX_W-1:0]    idx;
  logic [RES_BITS-1:0] acc;
  logic [RES_BITS-1:0] next_acc;

  assign busy       = (state != ST_IDLE);
  assign sh_sample  = (state == ST_SAMPLE);
  assign converting = (state == ST_CONV);
  assign next_acc   = RES_BITS'(sar_decide(16'(acc), 4'(idx), cmp_hi));
  assign done       = converting && (idx == '0) && !abort;
  assign result     = next_acc;
  assign dac_code   = converting ? RES_BITS'(sar_trial(16'(acc), 4'(idx))) : '0;
  assign trial_mask = converting ? (RES_BITS'(1) << idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      idx   <= '0;
      acc   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_SAMPLE;
            cnt   <= smp_len;
            acc   <= '0;
          end
        end
        ST_SAMPLE: begin
          if (abort) begin
            state <= ST_IDLE;
          end else if (cnt == '0) begin
            state <= ST_CONV;
            idx   <= IDX_W'(RES_BITS - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_CONV: begin
          if (abort) begin
            state <= ST_IDLE;
          end else begin
            acc <= next_acc;
            if (idx == '0) state <= ST_IDLE;
            else           idx   <= idx - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_regs.sv
module sar_regs #(
  parameter int RES_BITS = 12,
  parameter int NUM_CH   = 8,
  parameter int SMP_W    = 4,
  parameter int AW       = 3,
  parameter int DW       = 8,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [AW-1:0]       reg_addr,
  input  logic [DW-1:0]       reg_wdata,
  output logic [DW-1:0]       reg_rdata,
  input  logic                busy,
  input  logic                done,
  input  logic [RES_BITS-1:0] result,
  output logic                en,
  output logic [CH_W-1:0]     chan,
  output logic [1:0]          vref,
  output logic [SMP_W-1:0]    smp_len,
  output logic                start,
  output logic                abort,
  output logic                flag,
  output logic [NUM_CH-1:0]   ansel,
  output logic [RES_BITS-1:0] res_q
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_TIME = AW'(1);
  localparam logic [AW-1:0] A_RHI  = AW'(2);
  localparam logic [AW-1:0] A_RLO  = AW'(3);
  localparam logic [AW-1:0] A_FLAG = AW'(4);
  localparam logic [AW-1:0] A_MASK = AW'(5);

  logic wr_ctrl, wr_time, wr_flag, wr_mask;
  assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
  assign wr_time = reg_we && (reg_addr == A_TIME);
  assign wr_flag = reg_we && (reg_addr == A_FLAG);
  assign wr_mask = reg_we && (reg_addr == A_MASK);

  assign start = wr_ctrl && reg_wdata[0] && reg_wdata[1] && en && !busy;
  assign abort = wr_ctrl && busy && !(reg_wdata[0] && reg_wdata[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      chan    <= '0;
      vref    <= '0;
      smp_len <= '0;
      flag    <= 1'b0;
      ansel   <= '1;
    end else begin
      if (wr_ctrl) begin
        en   <= reg_wdata[0];
        chan <= reg_wdata[2 +: CH_W];
      end
      if (wr_time) begin
        vref    <= reg_wdata[1:0];
        smp_len <= reg_wdata[4 +: SMP_W];
      end
      if (wr_mask) ansel <= reg_wdata[NUM_CH-1:0];
      if (done)                         flag <= 1'b1;
      else if (wr_flag && !reg_wdata[0]) flag <= 1'b0;
    end
  end

  // Result pair: loaded only on completion, deliberately outside the reset.
  always_ff @(posedge clk) begin
    if (done) res_q <= result;
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTRL: begin
        reg_rdata[0]         = en;
        reg_rdata[1]         = busy;
        reg_rdata[2 +: CH_W] = chan;
      end
      A_TIME: begin
        reg_rdata[1:0]        = vref;
        reg_rdata[4 +: SMP_W] = smp_len;
      end
      A_RHI:  reg_rdata = DW'(res_q >> DW);
      A_RLO:  reg_rdata = res_q[DW-1:0];
      A_FLAG: reg_rdata[0] = flag;
      A_MASK: reg_rdata = DW'(ansel);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int RES_BITS = 12,
  parameter int NUM_CH   = 8,
  parameter int SMP_W    = 4,
  parameter int AW       = 3,
  parameter int DW       = 8,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [AW-1:0]       reg_addr,
  input  logic [DW-1:0]       reg_wdata,
  output logic [DW-1:0]       reg_rdata,
  output logic                irq,
  output logic                adc_on,
  output logic [CH_W-1:0]     chan_sel,
  output logic [1:0]          vref_sel,
  output logic                sh_sample,
  output logic [RES_BITS-1:0] dac_code,
  input  logic                cmp_hi,
  input  logic [NUM_CH-1:0]   pin_in,
  output logic [NUM_CH-1:0]   dig_in
);
  logic                busy, done, start_req, abort_req, converting;
  logic [SMP_W-1:0]    smp_len;
  logic [RES_BITS-1:0] result, res_q, trial_mask;
  logic [NUM_CH-1:0]   ansel;

  sar_regs #(
    .RES_BITS(RES_BITS), .NUM_CH(NUM_CH), .SMP_W(SMP_W), .AW(AW), .DW(DW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .done(done),
    .result(result), .en(adc_on), .chan(chan_sel), .vref(vref_sel),
    .smp_len(smp_len), .start(start_req), .abort(abort_req), .flag(irq),
    .ansel(ansel), .res_q(res_q)
  );

  sar_seq #(.RES_BITS(RES_BITS), .SMP_W(SMP_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_req), .abort(abort_req),
    .smp_len(smp_len), .cmp_hi(cmp_hi), .busy(busy), .sh_sample(sh_sample),
    .converting(converting), .done(done), .result(result),
    .dac_code(dac_code), .trial_mask(trial_mask)
  );

  sar_pinmux #(.NUM_CH(NUM_CH)) u_pins (
    .ansel(ansel), .pin_in(pin_in), .dig_in(dig_in)
  );
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int RES_BITS = 12,
  parameter int NUM_CH   = 8,
  parameter int AW       = 3,
  parameter int DW       = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_we,
  input logic [AW-1:0]       reg_addr,
  input logic [DW-1:0]       reg_wdata,
  input logic                busy,
  input logic                adc_on,
  input logic                irq,
  input logic                sh_sample,
  input logic                done,
  input logic                abort_req,
  input logic                converting,
  input logic [RES_BITS-1:0] trial_mask,
  input logic [RES_BITS-1:0] dac_code,
  input logic [RES_BITS-1:0] res_q,
  input logic [NUM_CH-1:0]   dig_in,
  input logic [NUM_CH-1:0]   ansel
);
  logic go_wr, clr_wr;
  assign go_wr  = reg_we && (reg_addr == AW'(0)) && reg_wdata[0] && reg_wdata[1];
  assign clr_wr = reg_we && (reg_addr == AW'(4)) && !reg_wdata[0];

  assert_sample_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> sh_sample);

  assert_trial_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    converting |-> ($onehot(trial_mask) && ((dac_code & (trial_mask - 1'b1)) == '0)
                    && ((dac_code & trial_mask) != '0)));

  assert_done_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && irq));

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_wr) |=> irq);

  assert_start_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go_wr && adc_on));

  assert_abort_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> (!busy && $stable(res_q) && $stable(irq)));

  always_comb begin
    assert_dig_mask_R10: assert ((dig_in & ansel) == '0);
  end
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(
  .RES_BITS(RES_BITS), .NUM_CH(NUM_CH), .AW(AW), .DW(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .busy(busy), .adc_on(adc_on), .irq(irq),
  .sh_sample(sh_sample), .done(done), .abort_req(abort_req),
  .converting(converting), .trial_mask(trial_mask), .dac_code(dac_code),
  .res_q(res_q), .dig_in(dig_in), .ansel(ansel)
);

// File: tb/sim_sar_adc_ctrl.sv
module sim_sar_adc_ctrl;
  localparam int PERIOD = 10;
  localparam int NVEC = 8;
  // {sample field[15:12], input level[11:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    16'h0000, 16'h1FFF, 16'h2800, 16'h37FF,
    16'hF001, 16'h5A5C, 16'h0555, 16'h9FFE
  };

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic irq, adc_on, sh_sample, cmp_hi;
  logic [2:0] chan_sel;
  logic [1:0] vref_sel;
  logic [11:0] dac_code, ain = '0;
  logic [7:0] pin_in = '0, dig_in;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;
  assign cmp_hi = (ain >= dac_code);

  sar_adc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .adc_on(adc_on),
    .chan_sel(chan_sel), .vref_sel(vref_sel), .sh_sample(sh_sample),
    .dac_code(dac_code), .cmp_hi(cmp_hi), .pin_in(pin_in), .dig_in(dig_in)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  // kind: 0 none, 1 write inj_d to address 0 at cycle inj_at, 2 reset pulse at inj_at
  task automatic run_conv(input logic [11:0] a, input int s, input int kind, input int inj_at,
                          input logic [7:0] inj_d, output int blen, output int shn,
                          output int dac_err);
    int n;
    wr(3'd1, 8'(s << 4));
    ain = a;
    wr(3'd0, 8'h03);
    n = 0; shn = 0; dac_err = 0;
    while (1) begin
      reg_addr = 3'd0;
      #1;
      if (!reg_rdata[1] || n > 300) break;
      if (sh_sample) shn++;
      else begin
        int idx, exp;
        idx = 11 - (n - (s + 1));
        exp = ((int'(a) >> (idx + 1)) << (idx + 1)) | (1 << idx);
        if (int'(dac_code) != exp) dac_err++;
      end
      if (n == inj_at && kind == 1) begin reg_wdata = inj_d; reg_we = 1'b1; end
      if (n == inj_at && kind == 2) rst_n = 1'b0;
      @(negedge clk);
      reg_we = 1'b0;
      rst_n  = 1'b1;
      n++;
    end
    blen = n;
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, blen, shn, derr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    rd(3'd0, v); chk("R1 ctrl", v, 0);
    rd(3'd1, v); chk("R1 time", v, 0);
    rd(3'd4, v); chk("R1 flag", v, 0);
    rd(3'd5, v); chk("R1 mask", v, 8'hFF);
    chk("R1 irq", int'(irq), 0);
    chk("R1 adc_on", int'(adc_on), 0);

    // R10 analog masking
    pin_in = 8'hFF; #1;
    chk("R10 all analog", int'(dig_in), 0);
    wr(3'd5, 8'h0F); #1;
    chk("R10 partial", int'(dig_in), 8'hF0);

    // R6 start while off is ignored (this write also turns the block on)
    wr(3'd0, 8'h03);
    rd(3'd0, v); chk("R6 off start ignored", v, 1);
    repeat (3) @(negedge clk);
    rd(3'd0, v); chk("R6 still idle", v & 2, 0);

    // R9 field outputs
    wr(3'd1, 8'h02);
    wr(3'd0, 8'h15); #1;
    chk("R9 chan", int'(chan_sel), 5);
    chk("R9 vref", int'(vref_sel), 2);
    chk("R9 on", int'(adc_on), 1);

    // Vector table: R2 R3 R4 R5
    for (int i = 0; i < NVEC; i++) begin
      int s; logic [11:0] a;
      s = int'(VEC[i][15:12]); a = VEC[i][11:0];
      run_conv(a, s, 0, -1, 8'h00, blen, shn, derr);
      chk("R2 busy length", blen, s + 13);
      chk("R2 sample cycles", shn, s + 1);
      chk("R3 trial codes", derr, 0);
      rd(3'd2, v); chk("R4 high", v, int'(a) >> 8);
      rd(3'd3, v); chk("R4 low", v, int'(a) & 8'hFF);
      chk("R5 irq set", int'(irq), 1);
      wr(3'd4, 8'h00);
      chk("R5 irq cleared", int'(irq), 0);
    end

    // R6 second start during a conversion
    run_conv(12'h6B1, 2, 1, 3, 8'h03, blen, shn, derr);
    chk("R6 length kept", blen, 15);
    rd(3'd3, v); chk("R6 result kept", v, 8'hB1);

    // R5 stickiness: writing 1 leaves the flag set
    wr(3'd4, 8'h01);
    repeat (5) @(negedge clk);
    chk("R5 sticky", int'(irq), 1);
    wr(3'd4, 8'h00);
    chk("R5 clear", int'(irq), 0);

    // R7 abort during the decision phase
    run_conv(12'h123, 0, 0, -1, 8'h00, blen, shn, derr);
    wr(3'd4, 8'h00);
    run_conv(12'hABC, 0, 1, 5, 8'h01, blen, shn, derr);
    chk("R7 stops", blen, 6);
    repeat (20) @(negedge clk);
    rd(3'd0, v); chk("R7 idle", v & 2, 0);
    rd(3'd2, v); chk("R7 high kept", v, 8'h01);
    rd(3'd3, v); chk("R7 low kept", v, 8'h23);
    chk("R7 no flag", int'(irq), 0);

    // R8 reset mid-conversion
    run_conv(12'h3C3, 1, 0, -1, 8'h00, blen, shn, derr);
    wr(3'd4, 8'h00);
    run_conv(12'h777, 2, 2, 6, 8'h00, blen, shn, derr);
    chk("R8 stops", blen, 7);
    rd(3'd0, v); chk("R8 ctrl reset", v, 0);
    rd(3'd1, v); chk("R8 time reset", v, 0);
    rd(3'd5, v); chk("R8 mask reset", v, 8'hFF);
    rd(3'd2, v); chk("R8 high kept", v, 8'h03);
    rd(3'd3, v); chk("R8 low kept", v, 8'hC3);
    chk("R8 no flag", int'(irq), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule